// File: doc/BRIEF.md
# Channel Protection Mode Sequencer

This controller takes one transceiver channel out of normal traffic and parks it in a protected self-test state. In that state the transmitter drives a PRBS7 pattern through an internal serial loopback and the output driver stays off. A single start pulse launches a fixed recipe of eighteen operations. The recipe disables the channel, requests an analog reset and waits until the reset completes. It then programs the encoding, the two line-rate multipliers, the pattern generator and the loopback. Next it captures three clocking registers and rewrites selected bits of each. The last operation re-enables transmit and receive.

Operations go out on one of two master ports. Abstract attribute writes (a 16-bit code and 16-bit data) use a request/done port. Byte-wide register accesses use a memory-mapped port with waitrequest and readdatavalid. Only one operation is in flight at any time. The three captured register values stay on read-only outputs after completion, so a later restore sequence can put them back. If the reset status never reports completion within a configurable number of cycles, the controller stops with an error flag.

Top module: `protmode_seq`

## Requirements
- R1: A start pulse while idle, done or in error launches the recipe from its first step, and busy is high while it runs. A start pulse while busy is ignored and does not restart the recipe.
- R2: The first operation is attribute code 0x0001 with data 0x0000. The last is attribute code 0x0001 with data 0x0003. After the last one, done rises and no further operation follows.
- R3: After the first attribute, the block writes bytes 0x00, 0x00, 0x00 and 0x81 to addresses 0x200, 0x201, 0x202 and 0x203, in that order. It then reads address 0x207 repeatedly until bit 0 of the returned byte is 1. Only bit 0 is examined.
- R4: After the status poll, attributes follow in this order: 0x0014/0x0055, 0x0005/{0x10, ref_mult}, 0x0006/{0x10, ref_mult}, 0x0002/0x0120 and 0x0008/0x0101.
- R5: Registers 0x05, 0x07 and 0x38 are read in that order before any write to them. The bytes read appear on saved_reg05, saved_reg07 and saved_reg38 and hold there after done.
- R6: Register 0x38 is read, then written with bits [1:0] = 2'b01 and bits [7:2] unchanged.
- R7: Register 0x07 is read, then written with bits 7 and 1 cleared and every other bit unchanged.
- R8: Register 0x05 is read, then written with bits [7:2] = 6'b000010 and bits [1:0] unchanged. The three read-modify-writes run in the order 0x38, 0x07, 0x05.
- R9: At most one of attr_req, bus_write and bus_read is high at a time. A bus command keeps its address and data stable while bus_waitreq is high. An attribute request keeps its code and data until attr_done. A read completes only on bus_rdvalid.
- R10: A status poll returns bit 0 = 0 after at least POLL_LIMIT cycles in the poll step. The block then raises error, drops busy and issues nothing more until the next start. That start clears error.
- R11: Done stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| ref_mult | input | 8 | Reference-clock multiplier for both rate attributes |
| busy | output | 1 | Recipe in progress |
| done | output | 1 | Recipe finished |
| error | output | 1 | Status poll timed out |
| attr_req | output | 1 | Attribute write request |
| attr_code | output | 16 | Attribute code |
| attr_data | output | 16 | Attribute data |
| attr_done | input | 1 | Attribute write accepted |
| bus_addr | output | ADDR_W | Register address |
| bus_write | output | 1 | Register write command |
| bus_read | output | 1 | Register read command |
| bus_wdata | output | 8 | Register write data |
| bus_waitreq | input | 1 | Command stall |
| bus_rdata | input | 8 | Register read data |
| bus_rdvalid | input | 1 | Read data valid |
| saved_reg05 | output | 8 | Captured value of register 0x05 |
| saved_reg07 | output | 8 | Captured value of register 0x07 |
| saved_reg38 | output | 8 | Captured value of register 0x38 |

## Verification
The hardest state to reach is the poll timeout. A sequence that ends in error has to be followed by a clean restart in which the stale timer must not fire. The bench shrinks POLL_LIMIT and runs a slave whose status byte never sets bit 0. It then restarts the block against a slave that completes on its first poll. A second hard case is a start pulse in the middle of a run. The bench injects one while busy, and its cycle-by-cycle model of the operation stream would flag any restarted first attribute. Random waitrequest stalls, random read latency and random attribute acceptance run throughout, and the status byte carries set upper bits so that only bit 0 can end the poll.

// File: rtl/protmode_pkg.sv
package protmode_pkg;

  localparam int REG_W   = 8;
  localparam int N_STEPS = 18;
  localparam int IDX_W   = $clog2(N_STEPS);
  localparam int N_SAVE  = 3;

  typedef enum logic [2:0] {
    OP_ATTR,
    OP_WR,
    OP_POLL,
    OP_SAVE,
    OP_RMW
  } op_t;

  typedef struct packed {
    op_t         kind;
    logic [15:0] code;
    logic [15:0] adata;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  mask;
    logic [1:0]  slot;
  } step_t;

  function automatic logic [15:0] rate_word(input logic [7:0] mult);
    return {8'h10, mult};
  endfunction

  function automatic logic [REG_W-1:0] rmw_merge(input logic [REG_W-1:0] old,
                                                 input logic [REG_W-1:0] mask,
                                                 input logic [REG_W-1:0] val);
    return (old & ~mask) | (val & mask);
  endfunction

  function automatic step_t mk(input op_t k, input logic [15:0] c, input logic [15:0] d,
                               input logic [15:0] a, input logic [7:0] w,
                               input logic [7:0] m, input logic [1:0] s);
    step_t t;
    t.kind  = k;
    t.code  = c;
    t.adata = d;
    t.addr  = a;
    t.wdata = w;
    t.mask  = m;
    t.slot  = s;
    return t;
  endfunction

  function automatic step_t step_at(input logic [IDX_W-1:0] i, input logic [7:0] mult);
    case (i)
      5'd0:    return mk(OP_ATTR, 16'h0001, 16'h0000, 16'h0, 8'h00, 8'h00, 2'd0);
      5'd1:    return mk(OP_WR,   16'h0,    16'h0,    16'h0200, 8'h00, 8'h00, 2'd0);
      5'd2:    return mk(OP_WR,   16'h0,    16'h0,    16'h0201, 8'h00, 8'h00, 2'd0);
      5'd3:    return mk(OP_WR,   16'h0,    16'h0,    16'h0202, 8'h00, 8'h00, 2'd0);
      5'd4:    return mk(OP_WR,   16'h0,    16'h0,    16'h0203, 8'h81, 8'h00, 2'd0);
      5'd5:    return mk(OP_POLL, 16'h0,    16'h0,    16'h0207, 8'h00, 8'h00, 2'd0);
      5'd6:    return mk(OP_ATTR, 16'h0014, 16'h0055, 16'h0, 8'h00, 8'h00, 2'd0);
      5'd7:    return mk(OP_ATTR, 16'h0005, rate_word(mult), 16'h0, 8'h00, 8'h00, 2'd0);
      5'd8:    return mk(OP_ATTR, 16'h0006, rate_word(mult), 16'h0, 8'h00, 8'h00, 2'd0);
      5'd9:    return mk(OP_ATTR, 16'h0002, 16'h0120, 16'h0, 8'h00, 8'h00, 2'd0);
      5'd10:   return mk(OP_ATTR, 16'h0008, 16'h0101, 16'h0, 8'h00, 8'h00, 2'd0);
      5'd11:   return mk(OP_SAVE, 16'h0,    16'h0,    16'h0005, 8'h00, 8'h00, 2'd0);
      5'd12:   return mk(OP_SAVE, 16'h0,    16'h0,    16'h0007, 8'h00, 8'h00, 2'd1);
      5'd13:   return mk(OP_SAVE, 16'h0,    16'h0,    16'h0038, 8'h00, 8'h00, 2'd2);
      5'd14:   return mk(OP_RMW,  16'h0,    16'h0,    16'h0038, 8'h01, 8'h03, 2'd0);
      5'd15:   return mk(OP_RMW,  16'h0,    16'h0,    16'h0007, 8'h00, 8'h82, 2'd0);
      5'd16:   return mk(OP_RMW,  16'h0,    16'h0,    16'h0005, 8'h08, 8'hFC, 2'd0);
      default: return mk(OP_ATTR, 16'h0001, 16'h0003, 16'h0, 8'h00, 8'h00, 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/protmode_step_table.sv
module protmode_step_table
  import protmode_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       mult,
  output step_t            step,
  output logic             is_last
);
  always_comb begin
    step    = step_at(idx, mult);
    is_last = (idx == IDX_W'(N_STEPS - 1));
  end
endmodule

// File: rtl/protmode_poll_timer.sv
module protmode_poll_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  // R10: once expired, the timer stays expired until cleared
  a_r10_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !clear |=> expired);
endmodule

// File: rtl/protmode_save_bank.sv
module protmode_save_bank #(
  parameter int N = 3,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] slot,
  input  logic [W-1:0]         wdata,
  output logic [N-1:0][W-1:0]  saved
);
  localparam int SW = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] held;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        held <= '0;
      else if (we && slot == SW'(g))     held <= wdata;
    end
    assign saved[g] = held;
  end

  // R5: captured values only change on a capture
  a_r5_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(saved));
endmodule

// File: rtl/protmode_seq.sv
module protmode_seq
  import protmode_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int POLL_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        ref_mult,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              attr_req,
  output logic [15:0]       attr_code,
  output logic [15:0]       attr_data,
  input  logic              attr_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_read,
  output logic [7:0]        bus_wdata,
  input  logic              bus_waitreq,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_rdvalid,
  output logic [7:0]        saved_reg05,
  output logic [7:0]        saved_reg07,
  output logic [7:0]        saved_reg38
);
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_ATTR, S_WR, S_RD, S_RDW, S_DONE, S_ERR
  } st_t;

  st_t              state, state_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [7:0]       rmw_q, rmw_n;
  step_t            step;
  logic             is_last;
  logic             tmr_expired;
  logic [N_SAVE-1:0][7:0] saved;

  // named internal events
  logic can_start, attr_fire, wr_fire, rd_fire, rd_back;
  logic poll_ok, poll_fail, save_we, tmr_clear, tmr_run;

  protmode_step_table u_table (
    .idx     (idx),
    .mult    (ref_mult),
    .step    (step),
    .is_last (is_last)
  );

  protmode_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  protmode_save_bank #(.N(N_SAVE), .W(8)) u_save (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (save_we),
    .slot  (step.slot),
    .wdata (bus_rdata),
    .saved (saved)
  );

  assign can_start = (state == S_IDLE) || (state == S_DONE) || (state == S_ERR);
  assign attr_fire = (state == S_ATTR) && attr_done;
  assign wr_fire   = (state == S_WR) && !bus_waitreq;
  assign rd_fire   = (state == S_RD) && !bus_waitreq;
  assign rd_back   = (state == S_RDW) && bus_rdvalid;
  assign poll_ok   = rd_back && (step.kind == OP_POLL) && bus_rdata[0];
  assign poll_fail = rd_back && (step.kind == OP_POLL) && !bus_rdata[0];
  assign save_we   = rd_back && (step.kind == OP_SAVE);
  assign tmr_clear = (state == S_ISSUE);
  assign tmr_run   = ((state == S_RD) || (state == S_RDW)) && (step.kind == OP_POLL);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    rmw_n   = rmw_q;
    case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          idx_n   = '0;
          state_n = S_ISSUE;
        end
      end
      S_ISSUE: begin
        case (step.kind)
          OP_ATTR: state_n = S_ATTR;
          OP_WR:   state_n = S_WR;
          default: state_n = S_RD;
        endcase
      end
      S_ATTR, S_WR: begin
        if (attr_fire || wr_fire) begin
          if (is_last) state_n = S_DONE;
          else begin
            idx_n   = idx + 1'b1;
            state_n = S_ISSUE;
          end
        end
      end
      S_RD: if (rd_fire) state_n = S_RDW;
      S_RDW: begin
        if (rd_back) begin
          if (step.kind == OP_RMW) begin
            rmw_n   = rmw_merge(bus_rdata, step.mask, step.wdata);
            state_n = S_WR;
          end else if (save_we || poll_ok) begin
            idx_n   = idx + 1'b1;
            state_n = S_ISSUE;
          end else if (tmr_expired) begin
            state_n = S_ERR;
          end else begin
            state_n = S_RD;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      rmw_q <= '0;
    end else begin
      state <= state_n;
      idx   <= idx_n;
      rmw_q <= rmw_n;
    end
  end

  assign busy        = !can_start;
  assign done        = (state == S_DONE);
  assign error       = (state == S_ERR);
  assign attr_req    = (state == S_ATTR);
  assign attr_code   = step.code;
  assign attr_data   = step.adata;
  assign bus_write   = (state == S_WR);
  assign bus_read    = (state == S_RD);
  assign bus_addr    = step.addr[ADDR_W-1:0];
  assign bus_wdata   = (step.kind == OP_RMW) ? rmw_q : step.wdata;
  assign saved_reg05 = saved[0];
  assign saved_reg07 = saved[1];
  assign saved_reg38 = saved[2];

  // R9: a single operation at a time on the two master ports
  a_r9_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({attr_req, bus_write, bus_read}));

  // R9: stalled write holds address and data
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write && bus_waitreq |=> bus_write && $stable(bus_addr) && $stable(bus_wdata));

  // R9: stalled read holds its address
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && bus_waitreq |=> bus_read && $stable(bus_addr));

  // R9: attribute request held until accepted
  a_r9_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    attr_req && !attr_done |=> attr_req && $stable(attr_code) && $stable(attr_data));

  // R10: a failed poll after expiry stops the block in error
  a_r10_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fail && tmr_expired |=> error && !busy);

  // R11: done holds until a new start
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R1: busy excludes both terminal flags
  a_r1_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (done || error)));
endmodule

// File: tb/protmode_seq_tb.sv
`timescale 1ns/1ps
module protmode_seq_tb;
  localparam int AW = 16;
  localparam int PL = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    ref_mult = 8'h00;
  logic          busy, done, error;
  logic          attr_req;
  logic [15:0]   attr_code, attr_data;
  logic          attr_done = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_write, bus_read;
  logic [7:0]    bus_wdata;
  logic          bus_waitreq = 1'b0;
  logic [7:0]    bus_rdata = 8'h00;
  logic          bus_rdvalid = 1'b0;
  logic [7:0]    sv05, sv07, sv38;

  always #4 clk = ~clk;

  protmode_seq #(.ADDR_W(AW), .POLL_LIMIT(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_mult(ref_mult),
    .busy(busy), .done(done), .error(error),
    .attr_req(attr_req), .attr_code(attr_code), .attr_data(attr_data), .attr_done(attr_done),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_read(bus_read), .bus_wdata(bus_wdata),
    .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata), .bus_rdvalid(bus_rdvalid),
    .saved_reg05(sv05), .saved_reg07(sv07), .saved_reg38(sv38)
  );

  // kind: 0 attribute (addr=code), 1 write, 2 read
  typedef struct {
    int    kind;
    int    addr;
    int    data;
    string tag;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         fails = 0;
  bit         poll_inf = 0;
  int         poll_ready = 1;
  int         poll_seen = 0;
  int         rd_pend = 0;
  logic [7:0] rd_val = 8'h00;
  logic [7:0] m05, m07, m38;
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input int d, input string t);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.tag = t;
    q.push_back(e);
  endtask

  task automatic build(input int mult, input int polls);
    q.delete();
    push(0, 'h0001, 'h0000, "R2");
    push(1, 'h200, 'h00, "R3");
    push(1, 'h201, 'h00, "R3");
    push(1, 'h202, 'h00, "R3");
    push(1, 'h203, 'h81, "R3");
    for (int i = 0; i < polls; i++) push(2, 'h207, 0, "R3");
    push(0, 'h0014, 'h0055, "R4");
    push(0, 'h0005, 'h1000 + mult, "R4");
    push(0, 'h0006, 'h1000 + mult, "R4");
    push(0, 'h0002, 'h0120, "R4");
    push(0, 'h0008, 'h0101, "R4");
    push(2, 'h05, 0, "R5");
    push(2, 'h07, 0, "R5");
    push(2, 'h38, 0, "R5");
    push(2, 'h38, 0, "R6");
    push(1, 'h38, int'({m38[7:2], 2'b01}), "R6");
    push(2, 'h07, 0, "R7");
    push(1, 'h07, int'(m07 & 8'b0111_1101), "R7");
    push(2, 'h05, 0, "R8");
    push(1, 'h05, int'({6'b000010, m05[1:0]}), "R8");
    push(0, 'h0001, 'h0003, "R2");
  endtask

  task automatic accept(input int k, input int a, input int d);
    exp_t e;
    longint act;
    act = (longint'(k) << 32) | (longint'(a) << 16) | longint'(d);
    if (q.size() == 0) begin
      chk(poll_inf && k == 2 && a == 'h207, "R2", "operation beyond expected stream", act, 0);
    end else begin
      e = q.pop_front();
      chk(k == e.kind && a == e.addr && (k == 2 || d == e.data), e.tag, "operation",
          act, (longint'(e.kind) << 32) | (longint'(e.addr) << 16) | longint'(e.kind == 2 ? d : e.data));
    end
  endtask

  // reference slave and stream comparison, every clock
  always @(negedge clk) begin
    bus_rdvalid = 1'b0;
    if (rd_pend > 0) begin
      rd_pend--;
      if (rd_pend == 0) begin
        bus_rdvalid = 1'b1;
        bus_rdata   = rd_val;
      end
    end
    bus_waitreq = ($urandom_range(0, 3) == 0);
    attr_done   = attr_req && ($urandom_range(0, 2) == 0);
    if (attr_req && attr_done) accept(0, int'(attr_code), int'(attr_data));
    if (bus_write && !bus_waitreq) begin
      accept(1, int'(bus_addr), int'(bus_wdata));
      case (int'(bus_addr))
        'h05: m05 = bus_wdata;
        'h07: m07 = bus_wdata;
        'h38: m38 = bus_wdata;
        default: ;
      endcase
    end
    if (bus_read && !bus_waitreq) begin
      accept(2, int'(bus_addr), 0);
      case (int'(bus_addr))
        'h05: rd_val = m05;
        'h07: rd_val = m07;
        'h38: rd_val = m38;
        'h207: begin
          poll_seen++;
          rd_val = (!poll_inf && poll_seen >= poll_ready) ? 8'hAB : 8'hAA;
        end
        default: rd_val = 8'h00;
      endcase
      rd_pend = 1 + $urandom_range(0, 1);
    end
  end

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_ok(input logic [7:0] mult, input int polls,
                        input logic [7:0] a05, input logic [7:0] a07,
                        input logic [7:0] a38, input bit poke);
    m05 = a05; m07 = a07; m38 = a38;
    poll_inf = 0; poll_seen = 0; poll_ready = polls;
    ref_mult = mult;
    build(int'(mult), polls);
    pulse_start();
    chk(busy, "R1", "busy after start", busy, 1);
    chk(!error, "R10", "error cleared by start", error, 0);
    chk(!done, "R11", "done cleared by start", done, 0);
    if (poke) begin
      repeat (12) @(negedge clk);
      chk(busy, "R1", "busy mid-run", busy, 1);
      pulse_start();
    end
    while (!done && !error) @(negedge clk);
    chk(done && !error, "R2", "finished cleanly", {done, error}, 2'b10);
    chk(!busy, "R1", "busy low at end", busy, 0);
    chk(q.size() == 0, "R2", "operations left", q.size(), 0);
    chk(sv05 == a05, "R5", "saved 0x05", sv05, a05);
    chk(sv07 == a07, "R5", "saved 0x07", sv07, a07);
    chk(sv38 == a38, "R5", "saved 0x38", sv38, a38);
    chk(m38 == {a38[7:2], 2'b01}, "R6", "final 0x38", m38, {a38[7:2], 2'b01});
    chk(m07 == (a07 & 8'h7D), "R7", "final 0x07", m07, a07 & 8'h7D);
    chk(m05 == {6'b000010, a05[1:0]}, "R8", "final 0x05", m05, {6'b000010, a05[1:0]});
    repeat (25) @(negedge clk);
    chk(done && !busy, "R11", "done held", done, 1);
    chk(!attr_req && !bus_read && !bus_write, "R2", "quiet after done",
        {attr_req, bus_read, bus_write}, 0);
    chk(sv05 == a05 && sv07 == a07 && sv38 == a38, "R5", "saved held after done",
        {sv05, sv07, sv38}, {a05, a07, a38});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !error, "R1", "reset flags", {busy, done, error}, 0);
    chk(!attr_req && !bus_read && !bus_write, "R9", "reset commands",
        {attr_req, bus_read, bus_write}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_ok(8'h34, 3, 8'hFF, 8'hFF, 8'hFC, 1'b1);
    run_ok(8'hA7, 1, 8'h00, 8'h82, 8'h02, 1'b0);

    // R10: status never completes
    m05 = 8'h11; m07 = 8'h22; m38 = 8'h33;
    build(8'h5C, 0);
    while (q.size() > 5) void'(q.pop_back());
    poll_inf = 1; poll_seen = 0; ref_mult = 8'h5C;
    pulse_start();
    while (!done && !error) @(negedge clk);
    chk(error && !busy && !done, "R10", "timeout flags", {error, busy, done}, 3'b100);
    chk(poll_seen >= 2, "R10", "polled more than once", poll_seen, 2);
    repeat (30) @(negedge clk);
    chk(error && !attr_req && !bus_read && !bus_write, "R10", "stopped in error",
        {error, attr_req, bus_read, bus_write}, 4'b1000);
    chk(q.size() == 0, "R3", "reset writes issued", q.size(), 0);

    run_ok(8'h01, 1, 8'hA5, 8'h5A, 8'hC3, 1'b0);

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      report();
      $finish;
    end
  end
endmodule